// File: doc/BRIEF.md
# MDIO Management Master with Host Port

This block connects a simple host register-access port to a two-wire Clause 22 management bus. The host sets a 2-bit opcode, a packed 10-bit address and 16 bits of write data, raises the MDIO-select input and pulses a one-cycle request. The block then sends one 64-bit management frame on MDC/MDIO, with the most significant bit first in every field. The frame holds a 32-bit preamble of ones, the start pattern 01, the opcode, the PHY address, the register address, a 2-bit turnaround and 16 data bits.

MDC comes from the host clock through a parameterised divider and stays low between frames. On a read, the block releases MDIO from the turnaround onward and captures the 16 data bits the PHY returns. The ready flag stays low for the whole frame. It rises again at the end of the frame, and on a read it also marks the cycle from which the read data is valid.

Top module: `mdio_master`

## Requirements
- R1: A request is accepted only when `host_req`, `host_sel` and `host_rdy` are all high at the same clock edge. A request with `host_sel` low has no effect: ready stays high, MDC stays low and MDIO is not driven.
- R2: Frame bits 0 to 31 are ones and bits 32 and 33 are 0 then 1. Bits 34 and 35 are `host_op[1:0]`, bits 36 to 40 are `host_addr[9:5]` and bits 41 to 45 are `host_addr[4:0]`. Bit 0 is sent first, and each field goes out MSB first.
- R3: For any opcode other than 2'b10, the block drives all 64 bits. The turnaround (bits 46 and 47) is 1 then 0, and bits 48 to 63 are the `host_wdata` value sampled at the accepting edge, MSB first. Later changes to `host_wdata` have no effect on the frame.
- R4: For opcode 2'b10 (read), `mdio_oe` is low from bit 46 to the end of the frame. The 16 values of `mdio_i` sampled on the MDC rising edges of bits 48 to 63 (MSB first) appear on `host_rdata` in the same cycle that ready rises. `host_rdata` then holds that value until the next read completes, and writes leave it unchanged.
- R5: `host_rdy` falls at the accepting edge and stays low until exactly 128*MDC_HALF host clock edges later, which is the falling MDC edge that ends bit 63.
- R6: A request that arrives while a frame is in progress is dropped. It does not change the current frame and it does not start a second frame afterwards.
- R7: While idle, MDC is low. After an accepting edge, MDC toggles every MDC_HALF host clocks, so its period is 2*MDC_HALF clocks. The default of 25 gives a 400 ns period at 125 MHz.
- R8: During a frame, `mdio_o` changes only at MDC falling edges, and each bit is held for one full MDC period starting at the accepting edge. `mdio_i` is sampled only at MDC rising edges.
- R9: After reset, `host_rdy` is 1, `mdc` is 0, `mdio_oe` is 0 and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Marks the request as a management bus access |
| host_op | input | 2 | Opcode placed in the frame (10 = read) |
| host_addr | input | 10 | PHY address in [9:5], register address in [4:0] |
| host_wdata | input | 16 | Data field for non-read frames |
| host_req | input | 1 | One-cycle request pulse |
| host_rdata | output | 16 | Data captured by the last read |
| host_rdy | output | 1 | High when idle; rises at the end of each frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for MDIO |
| mdio_i | input | 1 | Serial data in |

## Verification
A per-cycle reference model checks MDC phase, bit timing and the serial bits. A design that is one host clock early or late on any MDC edge, or that shifts data on the rising edge, is caught within one bit. One request is pulsed mid-frame with different fields, to catch a design that restarts the frame, corrupts its fields or queues a second frame. Write data is changed after acceptance, to catch a design that samples it late. A request with select low and a non-standard opcode (11) are also applied, to catch a design that starts without select or releases MDIO on anything but a read. Read data is compared on the exact cycle ready rises and again after a later write, to catch data that shows up late or is overwritten by a write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int DATA_W     = 16;
    localparam int FLD_W      = 5;
    localparam int BIDX_W     = $clog2(FRAME_BITS);

    typedef logic [1:0] op_t;
    localparam op_t OP_READ = 2'b10;

    typedef struct packed {
        op_t               op;
        logic [FLD_W-1:0]  phy;
        logic [FLD_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } xact_t;

    function automatic logic is_read(op_t op);
        return op == OP_READ;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(xact_t x);
        return {32'hFFFF_FFFF, 2'b01, x.op, x.phy, x.regad, 2'b10, x.wdata};
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int MDC_HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(MDC_HALF - 1));
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xact_t             xact,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              finish,
    output logic              rd,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] cap
);
    logic [FRAME_BITS-1:0] sr;
    logic [BIDX_W-1:0]     bidx;

    assign finish  = busy && fall && (bidx == BIDX_W'(FRAME_BITS - 1));
    assign mdio_o  = busy ? sr[FRAME_BITS-1] : 1'b0;
    assign mdio_oe = busy && !(rd && (bidx >= BIDX_W'(TA_POS)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            rd   <= 1'b0;
            sr   <= '0;
            bidx <= '0;
            cap  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            rd   <= is_read(xact.op);
            sr   <= build_frame(xact);
            bidx <= '0;
        end else if (busy) begin
            if (rise && rd && (bidx >= BIDX_W'(DATA_POS)))
                cap <= {cap[DATA_W-2:0], mdio_i};
            if (fall) begin
                sr <= sr << 1;
                if (finish) busy <= 1'b0;
                else        bidx <= bidx + 1'b1;
            end
        end
    end

    // R6: a frame in flight keeps its direction whatever the host does
    a_r6_frame_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rd));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel,
    input  logic [1:0]  host_op,
    input  logic [9:0]  host_addr,
    input  logic [15:0] host_wdata,
    input  logic        host_req,
    output logic [15:0] host_rdata,
    output logic        host_rdy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              accept;
    logic              busy;
    logic              finish;
    logic              rd;
    logic              rise;
    logic              fall;
    logic [DATA_W-1:0] cap;
    xact_t             xact;

    assign accept = host_req && host_sel && host_rdy;
    assign xact   = '{op: host_op, phy: host_addr[9:5],
                      regad: host_addr[4:0], wdata: host_wdata};

    mdio_clkdiv #(.MDC_HALF(MDC_HALF)) u_div (
        .clk(clk), .rst(rst), .run(busy),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst(rst), .start(accept), .xact(xact),
        .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .busy(busy), .finish(finish), .rd(rd),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdy   <= 1'b1;
            host_rdata <= '0;
        end else if (accept) begin
            host_rdy <= 1'b0;
        end else if (finish) begin
            host_rdy <= 1'b1;
            if (rd) host_rdata <= cap;
        end
    end

    // R5: the host never sees ready during a frame
    a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        busy |-> !host_rdy);

    // R1: a request without select leaves the block idle
    a_r1_sel_gate: assert property (@(posedge clk) disable iff (rst)
        (host_rdy && host_req && !host_sel) |=> host_rdy);

    // R7: MDC is parked low whenever no frame runs
    a_r7_idle_mdc: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R8: serial output moves only with a falling MDC edge
    a_r8_drive_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    // R8: captured read bits move only with a rising MDC edge
    a_r8_sample_on_rise: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cap)) |-> $rose(mdc));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 25;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic [1:0]  host_op = 2'b00;
    logic [9:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_req = 1'b0;
    logic [15:0] host_rdata;
    logic        host_rdy;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    mdio_master #(.MDC_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_op(host_op),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_req(host_req),
        .host_rdata(host_rdata), .host_rdy(host_rdy), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // reference model state
    logic        m_busy = 1'b0;
    int          m_t = 0;
    logic [63:0] m_frame = '0;
    logic        m_read = 1'b0;
    logic [15:0] m_rdata = '0;
    logic [15:0] phy_data = 16'h0000;
    int          nfall = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 1'b0; m_t = 0; m_rdata = '0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == FRAME_CYC) begin
                m_busy = 1'b0;
                if (m_read) m_rdata = phy_data;
            end
        end else if (host_req && host_sel) begin
            m_busy  = 1'b1;
            m_t     = 0;
            nfall   = 0;
            m_read  = (host_op == 2'b10);
            m_frame = {32'hFFFF_FFFF, 2'b01, host_op, host_addr, 2'b10, host_wdata};
        end
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // PHY model: drives read data after MDC falls
    always @(negedge mdc) begin
        nfall = nfall + 1;
        if (nfall == 47)
            mdio_i = 1'b0;
        else if (nfall >= 48 && nfall < 64)
            mdio_i = phy_data[15 - (nfall - 48)];
        else
            mdio_i = 1'b1;
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int bitn;
            logic e_mdc, e_oe;
            bitn  = m_t / (2 * HALF);
            e_mdc = m_busy ? logic'((m_t / HALF) % 2) : 1'b0;
            e_oe  = m_busy && !(m_read && bitn >= 46);
            check(host_rdy == !m_busy, "R5 ready", host_rdy, !m_busy);
            check(mdc == e_mdc, "R7 mdc", mdc, e_mdc);
            check(mdio_oe == e_oe, m_read ? "R4 oe" : "R3 oe", mdio_oe, e_oe);
            if (e_oe && mdio_oe)
                check(mdio_o == m_frame[63 - bitn], bitn < 46 ? "R2 R8 bit" : "R3 R8 bit",
                      mdio_o, m_frame[63 - bitn]);
            check(host_rdata == m_rdata, "R4 rdata", host_rdata, m_rdata);
        end
    end

    task automatic issue(input logic sel, input logic [1:0] op,
                         input logic [9:0] addr, input logic [15:0] wd);
        @(posedge clk); #2;
        host_sel = sel; host_op = op; host_addr = addr; host_wdata = wd; host_req = 1'b1;
        @(posedge clk); #2;
        host_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        repeat (5) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(host_rdy == 1'b1, "R9 rdy", host_rdy, 1);
        check(mdc == 1'b0, "R9 mdc", mdc, 0);
        check(mdio_oe == 1'b0, "R9 oe", mdio_oe, 0);
        check(host_rdata == 16'h0, "R9 rdata", host_rdata, 0);

        // R1: select low, nothing happens
        issue(1'b0, 2'b01, 10'h155, 16'hBEEF);
        repeat (3 * HALF) @(posedge clk);
        @(negedge clk);
        check(host_rdy && !mdc && !mdio_oe, "R1 sel low ignored", {host_rdy, mdc, mdio_oe}, 3'b100);

        // R2 R3: write, data changed after acceptance
        issue(1'b1, 2'b01, 10'h2A5, 16'hA5C3);
        host_wdata = 16'h0000;
        wait_idle();

        // R4: read
        phy_data = 16'h9E37;
        issue(1'b1, 2'b10, 10'h3E1, 16'h1111);
        wait_idle();
        @(negedge clk);
        check(host_rdata == 16'h9E37, "R4 read value", host_rdata, 16'h9E37);

        // R4: write leaves read data alone; R6 request mid-frame dropped
        issue(1'b1, 2'b01, 10'h0F0, 16'h5A5A);
        repeat (40 * HALF) @(posedge clk);
        #2 host_sel = 1'b1; host_op = 2'b10; host_addr = 10'h3FF; host_wdata = 16'hFFFF; host_req = 1'b1;
        @(posedge clk); #2 host_req = 1'b0;
        wait_idle();
        repeat (3 * HALF) @(posedge clk);
        @(negedge clk);
        check(host_rdy && !mdc, "R6 no queued frame", {host_rdy, mdc}, 2'b10);
        check(host_rdata == 16'h9E37, "R4 held after write", host_rdata, 16'h9E37);

        // R3: opcode 11 drives full frame
        issue(1'b1, 2'b11, 10'h001, 16'h0001);
        wait_idle();

        // R4: second read, boundary patterns
        phy_data = 16'h8001;
        issue(1'b1, 2'b10, 10'h000, 16'h0000);
        wait_idle();
        @(negedge clk);
        check(host_rdata == 16'h8001, "R4 second read", host_rdata, 16'h8001);

        // back-to-back accept right after ready returns
        phy_data = 16'h7FFE;
        issue(1'b1, 2'b10, 10'h3FF, 16'h0);
        while (!host_rdy) @(posedge clk);
        #2 host_op = 2'b01; host_wdata = 16'hFFFF; host_req = 1'b1;
        @(posedge clk); #2 host_req = 1'b0;
        wait_idle();
        @(negedge clk);
        check(host_rdata == 16'h7FFE, "R4 R5 back to back", host_rdata, 16'h7FFE);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule